// File: doc/BRIEF.md
# TDM Receive Frame Sync Aligner

This block locates the start of every received TDM frame and turns the serial bits that follow into parallel words. It runs entirely on a fast system clock. The receive bit clock, the frame sync and the serial data arrive as asynchronous inputs and are brought into the system domain together. The rising and falling edges of the bit clock are found by comparing consecutive synchronized samples. The system clock must run at least four times faster than the bit clock.

Static configuration chooses several settings:
- which bit-clock edge samples the sync;
- which bit-clock edge samples the data;
- the active level of the sync;
- the word length, 8 or 16 bits;
- the delay, in bit clocks, from the sync to the first data bit.

When sync and data use different edges, the first bit falls half a bit clock later than the delay alone would place it. A frame carries `FRAME_BITS` bits. A sync that arrives while a frame is still being received restarts the frame and raises an error flag.

Top module: `rx_frame_aligner`

## Requirements
- R1: The sync is sampled on rising bit-clock edges when `cfg_sync_fall` is 0, and on falling edges when it is 1.
- R2: Data is sampled on rising bit-clock edges when `cfg_data_fall` is 0, and on falling edges when it is 1.
- R3: With `cfg_sync_low` at 0 the sync is active when high; with it at 1 the sync is active when low.
- R4: When sync and data use the same edge, the first data bit is the one sampled `cfg_delay` bit clocks after the sampled leading edge of the sync. A delay of 0 takes the bit sampled at that same edge.
- R5: When sync and data use different edges, the first data bit is sampled `cfg_delay` + 0.5 bit clocks after the sync's leading edge.
- R6: Only a sampled change of the sync from inactive to active starts a frame. A sync held active starts nothing more. `frame_start` is a one-cycle pulse for each start.
- R7: Bits are packed MSB first into words of 16 bits (`cfg_word_wide`=1) or 8 bits (`cfg_word_wide`=0). In 8-bit mode the word sits in `rx_word[7:0]` and bits 15:8 read 0. `word_valid` is high for exactly one cycle per completed word.
- R8: A frame ends after `FRAME_BITS` bits. `bit_cnt` returns to 0 at each frame start, counts the bits taken in the current frame, and holds its value once the frame has ended.
- R9: A frame start while a frame is in progress restarts the bit count and the word assembly, dropping the partial word. It raises `sync_err` for one cycle, together with `frame_start`.
- R10: While reset is held, `frame_start`, `word_valid`, `sync_err`, `rx_word` and `bit_cnt` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_bclk | input | 1 | Receive bit clock (asynchronous) |
| rx_fsync | input | 1 | Receive frame sync (asynchronous) |
| rx_sdata | input | 1 | Serial receive data (asynchronous) |
| cfg_sync_fall | input | 1 | Sync sampling edge: 0 rising, 1 falling |
| cfg_data_fall | input | 1 | Data sampling edge: 0 rising, 1 falling |
| cfg_sync_low | input | 1 | Sync polarity: 0 active high, 1 active low |
| cfg_word_wide | input | 1 | Word length: 0 = 8 bits, 1 = 16 bits |
| cfg_delay | input | DLY_W | Sync-to-first-bit delay in bit clocks |
| frame_start | output | 1 | One-cycle pulse for each frame start |
| rx_word | output | W_LONG | Last completed word |
| word_valid | output | 1 | One-cycle strobe when `rx_word` updates |
| sync_err | output | 1 | One-cycle pulse when a sync arrives mid-frame |
| bit_cnt | output | CNT_W | Bits taken in the current frame |

## Verification
The stimulus covers all eight combinations of sync edge, data edge and polarity, with delays from 0 to the maximum, followed by random configurations and random data. A delay of 0 with matching edges shows whether the bit sampled at the sync edge itself is taken. Mixed edges show whether the half-bit offset is present or missing. Four sync shapes are used, and each separates a different fault:
- a single short pulse gives the plain alignment;
- two separated frames show that the state rearms cleanly;
- a sync held across the whole frame catches level-triggered starts;
- a sync placed in the middle of a frame must produce an error and a realigned word stream.

// File: rtl/rxfa_pkg.sv
// Shared types for the receive frame sync aligner.
package rxfa_pkg;

    // Frame tracking state: idle, counting the delay, taking bits.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } fr_state_t;

endpackage

// File: rtl/rxfa_edge_sync.sv
// Synchronizes bit clock, frame sync and data into the system clock
// through the same number of flops, then flags the bit-clock edges.
// Assumes the system clock is at least 4x the bit clock and that sync and
// data are stable around the edge that samples them.
module rxfa_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_in,
    input  logic fsync_in,
    input  logic sdata_in,
    output logic s_fs,
    output logic s_dat,
    output logic bclk_rise,
    output logic bclk_fall
);
    localparam int NSIG = 3;

    logic [NSIG-1:0] stg [STAGES];
    logic            clk_prev;

    // Synchronizer chain: all three inputs see equal latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= {bclk_in, fsync_in, sdata_in};
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    // Previous synchronized bit-clock level, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_prev <= 1'b0;
        else        clk_prev <= stg[STAGES-1][2];
    end

    assign s_fs      = stg[STAGES-1][1];
    assign s_dat     = stg[STAGES-1][0];
    assign bclk_rise =  stg[STAGES-1][2] & ~clk_prev;
    assign bclk_fall = ~stg[STAGES-1][2] &  clk_prev;

endmodule

// File: rtl/rxfa_frame_ctl.sv
// Finds frame starts on the sampled sync, counts the sync-to-data delay in
// data events and marks which data events carry frame bits.
// Assumes sync_evt and data_evt are single-cycle strobes of the chosen edges.
module rxfa_frame_ctl
    import rxfa_pkg::*;
#(
    parameter int DLY_W      = 3,
    parameter int FRAME_BITS = 32,
    parameter int CNT_W      = $clog2(FRAME_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_evt,
    input  logic             data_evt,
    input  logic             s_fs,
    input  logic             sync_low,
    input  logic             edges_differ,
    input  logic [DLY_W-1:0] delay,
    output logic             capture,
    output logic             restart,
    output logic             frame_start,
    output logic             sync_err,
    output logic [CNT_W-1:0] bit_cnt
);
    localparam int TW = DLY_W + 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    fr_state_t        st;
    logic             fs_prev;
    logic             fs_act;
    logic             start;
    logic             last;
    logic [TW-1:0]    target;
    logic [TW-1:0]    wcnt;
    logic [CNT_W-1:0] base_cnt;

    assign fs_act  = s_fs ^ sync_low;
    assign start   = sync_evt & fs_act & ~fs_prev;
    assign restart = start;
    assign target  = {1'b0, delay} + TW'(edges_differ);

    // Previous sampled sync activity, updated only on sync edges.
    always_ff @(posedge clk) begin
        if (!rst_n)        fs_prev <= 1'b0;
        else if (sync_evt) fs_prev <= fs_act;
    end

    // Decide whether this cycle takes a frame bit.
    always_comb begin
        if (start)
            capture = (target == '0);
        else if (data_evt)
            capture = (st == ST_RUN) || (st == ST_WAIT && wcnt == TW'(1));
        else
            capture = 1'b0;
        base_cnt = start ? '0 : bit_cnt;
        last     = capture && (base_cnt == LAST_BIT);
    end

    // Frame state, delay countdown and bit count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            wcnt    <= '0;
            bit_cnt <= '0;
        end else if (start) begin
            wcnt    <= target;
            bit_cnt <= capture ? CNT_W'(1) : '0;
            if (target != '0) st <= ST_WAIT;
            else              st <= last ? ST_IDLE : ST_RUN;
        end else if (capture) begin
            bit_cnt <= bit_cnt + CNT_W'(1);
            st      <= last ? ST_IDLE : ST_RUN;
        end else if (st == ST_WAIT && data_evt) begin
            wcnt <= wcnt - TW'(1);
        end
    end

    // Registered start and mid-frame error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_start <= 1'b0;
            sync_err    <= 1'b0;
        end else begin
            frame_start <= start;
            sync_err    <= start && (st != ST_IDLE);
        end
    end

    assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);
    assert_err_with_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> frame_start);
    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(FRAME_BITS));
    assert_cnt_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (bit_cnt <= CNT_W'(1)));

endmodule

// File: rtl/rxfa_word_pack.sv
// Packs frame bits MSB first into 8- or 16-bit words and strobes each
// completed word. Assumes restart marks a frame start and discards any
// partial word; a bit captured in the same cycle is the new first bit.
module rxfa_word_pack #(
    parameter int W_LONG  = 16,
    parameter int W_SHORT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              restart,
    input  logic              bit_in,
    input  logic              wide,
    output logic [W_LONG-1:0] rx_word,
    output logic              word_valid
);
    localparam int WC_W = $clog2(W_LONG);
    localparam logic [W_LONG-1:0] SHORT_MASK = {{(W_LONG-W_SHORT){1'b0}}, {W_SHORT{1'b1}}};

    logic [W_LONG-1:0] sh, base_sh, nsh;
    logic [WC_W-1:0]   cnt, base_cnt, last_idx;

    // Operands for this cycle, cleared when a frame restarts.
    always_comb begin
        base_sh  = restart ? '0 : sh;
        base_cnt = restart ? '0 : cnt;
        nsh      = {base_sh[W_LONG-2:0], bit_in};
        last_idx = wide ? WC_W'(W_LONG - 1) : WC_W'(W_SHORT - 1);
    end

    // Shift register, fill count and output word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh         <= '0;
            cnt        <= '0;
            rx_word    <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (capture) begin
                if (base_cnt == last_idx) begin
                    rx_word    <= wide ? nsh : (nsh & SHORT_MASK);
                    word_valid <= 1'b1;
                    sh         <= '0;
                    cnt        <= '0;
                end else begin
                    sh  <= nsh;
                    cnt <= base_cnt + WC_W'(1);
                end
            end else if (restart) begin
                sh  <= '0;
                cnt <= '0;
            end
        end
    end

    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);
    assert_short_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !wide) |-> (rx_word[W_LONG-1:W_SHORT] == '0));

endmodule

// File: rtl/rx_frame_aligner.sv
// Top of the receive frame sync aligner: selects the sampling edges for
// sync and data, then ties the synchronizer, frame control and packer.
// Assumes configuration is static while out of reset.
module rx_frame_aligner #(
    parameter int DLY_W       = 3,
    parameter int FRAME_BITS  = 32,
    parameter int W_LONG      = 16,
    parameter int W_SHORT     = 8,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = $clog2(FRAME_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_bclk,
    input  logic              rx_fsync,
    input  logic              rx_sdata,
    input  logic              cfg_sync_fall,
    input  logic              cfg_data_fall,
    input  logic              cfg_sync_low,
    input  logic              cfg_word_wide,
    input  logic [DLY_W-1:0]  cfg_delay,
    output logic              frame_start,
    output logic [W_LONG-1:0] rx_word,
    output logic              word_valid,
    output logic              sync_err,
    output logic [CNT_W-1:0]  bit_cnt
);
    logic s_fs, s_dat, rise, fall;
    logic sync_evt, data_evt, capture, restart;

    rxfa_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .bclk_in(rx_bclk), .fsync_in(rx_fsync), .sdata_in(rx_sdata),
        .s_fs(s_fs), .s_dat(s_dat), .bclk_rise(rise), .bclk_fall(fall)
    );

    assign sync_evt = cfg_sync_fall ? fall : rise;
    assign data_evt = cfg_data_fall ? fall : rise;

    rxfa_frame_ctl #(.DLY_W(DLY_W), .FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .sync_evt(sync_evt), .data_evt(data_evt), .s_fs(s_fs),
        .sync_low(cfg_sync_low), .edges_differ(cfg_sync_fall ^ cfg_data_fall),
        .delay(cfg_delay),
        .capture(capture), .restart(restart),
        .frame_start(frame_start), .sync_err(sync_err), .bit_cnt(bit_cnt)
    );

    rxfa_word_pack #(.W_LONG(W_LONG), .W_SHORT(W_SHORT)) u_pack (
        .clk(clk), .rst_n(rst_n),
        .capture(capture), .restart(restart), .bit_in(s_dat),
        .wide(cfg_word_wide),
        .rx_word(rx_word), .word_valid(word_valid)
    );

    assert_capture_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> data_evt);

endmodule

// File: tb/rx_frame_aligner_tb_top.sv
// Bench: drives edge-by-edge bit-clock patterns and compares the word
// stream, start and error counts and the bit count with a bench model.
module rx_frame_aligner_tb_top;
    localparam int FB = 32;
    localparam int DW = 3;
    localparam int NE = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_bclk = 1'b0, rx_fsync = 1'b0, rx_sdata = 1'b0;
    logic cfg_sync_fall = 1'b0, cfg_data_fall = 1'b0, cfg_sync_low = 1'b0, cfg_word_wide = 1'b0;
    logic [DW-1:0] cfg_delay = '0;
    logic frame_start, word_valid, sync_err;
    logic [15:0] rx_word;
    logic [5:0] bit_cnt;

    always #2 clk = ~clk;

    rx_frame_aligner dut_i (
        .clk(clk), .rst_n(rst_n), .rx_bclk(rx_bclk), .rx_fsync(rx_fsync), .rx_sdata(rx_sdata),
        .cfg_sync_fall(cfg_sync_fall), .cfg_data_fall(cfg_data_fall),
        .cfg_sync_low(cfg_sync_low), .cfg_word_wide(cfg_word_wide), .cfg_delay(cfg_delay),
        .frame_start(frame_start), .rx_word(rx_word), .word_valid(word_valid),
        .sync_err(sync_err), .bit_cnt(bit_cnt)
    );

    int total = 0, failed = 0;
    logic sync_e [NE];
    logic data_e [NE];
    logic [15:0] exp_w [64];
    logic [15:0] got_w [64];
    int exp_n, exp_fs, exp_err, exp_bits;
    int got_n = 0, got_fs = 0, got_err = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor outputs half a cycle after the edge that updates them.
    always @(negedge clk) begin
        if (rst_n) begin
            if (word_valid) begin
                if (got_n < 64) got_w[got_n] = rx_word;
                got_n++;
            end
            if (frame_start) got_fs++;
            if (sync_err) got_err++;
        end
    end

    // Sync pattern per shape; value held over both edges of each sync bit.
    task automatic build_pattern(input bit sf, input bit pol, input int ptype);
        int starts[3];
        int ns, w;
        for (int e = 0; e < NE; e++) begin
            sync_e[e] = pol;
            data_e[e] = 1'($urandom);
        end
        case (ptype)
            0: begin starts[0] = 10; ns = 1; w = 1; end
            1: begin starts[0] = 10; starts[1] = 120; ns = 2; w = 2; end
            2: begin starts[0] = 10; ns = 1; w = 45; end
            default: begin starts[0] = 10; starts[1] = 50; starts[2] = 150; ns = 3; w = 1; end
        endcase
        for (int k = 0; k < ns; k++)
            for (int e = starts[k] + int'(sf); e < starts[k] + int'(sf) + 2*w && e < NE; e++)
                sync_e[e] = ~pol;
    endtask

    // Bench model built from the requirements.
    task automatic exp_model(input bit sf, input bit df, input bit pol, input bit wide, input int dly);
        bit prev = 0, inf = 0, act;
        int first = 0, bi = 0, wb = 0, wl;
        logic [15:0] w = '0;
        wl = wide ? 16 : 8;
        exp_n = 0; exp_fs = 0; exp_err = 0;
        for (int e = 0; e < NE; e++) begin
            if ((e % 2) == int'(sf)) begin
                act = sync_e[e] ^ pol;
                if (act && !prev) begin
                    if (inf) exp_err++;
                    exp_fs++;
                    inf = 1; bi = 0; wb = 0; w = '0;
                    first = e + 2*dly + ((sf != df) ? 1 : 0);
                end
                prev = act;
            end
            if (inf && (e % 2) == int'(df) && e >= first) begin
                w = {w[14:0], data_e[e]};
                wb++; bi++;
                if (wb == wl) begin
                    exp_w[exp_n] = wide ? w : {8'h00, w[7:0]};
                    exp_n++; wb = 0; w = '0;
                end
                if (bi == FB) inf = 0;
            end
        end
        exp_bits = bi;
    endtask

    task automatic run_scn(input bit sf, input bit df, input bit pol, input bit wide,
                           input int dly, input int ptype);
        string vtag, ftag;
        build_pattern(sf, pol, ptype);
        exp_model(sf, df, pol, wide, dly);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_sync_fall = sf; cfg_data_fall = df; cfg_sync_low = pol;
        cfg_word_wide = wide; cfg_delay = DW'(dly);
        rx_bclk = 1'b0; rx_fsync = pol; rx_sdata = 1'b0;
        repeat (4) @(negedge clk);
        got_n = 0; got_fs = 0; got_err = 0;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        for (int e = 0; e < NE; e++) begin
            rx_fsync = sync_e[e];
            rx_sdata = data_e[e];
            repeat (2) @(negedge clk);
            rx_bclk = ~rx_bclk;
            repeat (2) @(negedge clk);
        end
        repeat (12) @(negedge clk);
        vtag = (sf != df) ? "R5 half-bit offset" : (df ? "R2 falling data edge" : "R4 same-edge delay");
        ftag = (ptype == 2) ? "R6 held sync" : (pol ? "R3 active-low sync" : "R1 sync edge");
        check(got_n == exp_n, "R7 word count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n && i < 64; i++)
            check(got_w[i] == exp_w[i], vtag, int'(got_w[i]), int'(exp_w[i]));
        check(got_fs == exp_fs, ftag, got_fs, exp_fs);
        check(got_err == exp_err, "R9 mid-frame sync error", got_err, exp_err);
        check(int'(bit_cnt) == exp_bits, "R8 bit count", int'(bit_cnt), exp_bits);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; failed++;
        $display("FAIL R8 watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R10: outputs under reset.
        repeat (4) @(negedge clk);
        check(frame_start == 1'b0, "R10 frame_start in reset", int'(frame_start), 0);
        check(word_valid == 1'b0, "R10 word_valid in reset", int'(word_valid), 0);
        check(sync_err == 1'b0, "R10 sync_err in reset", int'(sync_err), 0);
        check(rx_word == 16'h0, "R10 rx_word in reset", int'(rx_word), 0);
        check(bit_cnt == '0, "R10 bit_cnt in reset", int'(bit_cnt), 0);
        // Directed: every edge/polarity combination, delays 0..7, all shapes.
        for (int i = 0; i < 8; i++)
            run_scn(i[0], i[1], i[2], i[0] ^ i[2], (i * 3) % 8, i % 4);
        // Corner: maximum delay with a mid-frame resync on matching edges.
        run_scn(1'b1, 1'b1, 1'b0, 1'b1, 7, 3);
        // Random configurations and data.
        for (int n = 0; n < 24; n++)
            run_scn(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                    int'($urandom % 8), int'($urandom % 4));
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule